// File: doc/BRIEF.md
# Buffered Full-Duplex UART Transceiver

This block is an asynchronous serial transceiver with independent transmit and receive paths that run at the same time. It does not make its own baud timer. Instead it takes a single-cycle enable, `baud_tick`, from an external rate timer. It derives a bit-rate transfer clock from that enable by dividing by 8 or by 16. The `div_sel` input picks the ratio, and the same ratio applies whichever way the external timer is configured. All internal timing is measured in half transfer clocks.

Transmission begins only when the one-entry transmit buffer is written. The `tx_full` flag shows that the buffer holds a byte that is still being sent. The line stays idle for a fixed 2.5 transfer clocks after the write. The frame then goes out: a low start bit, eight data bits with the least significant bit first, and a high stop bit. The receiver watches a synchronised copy of `rxd`. It accepts a start bit only after the line has stayed low for half a transfer clock. It then samples each bit at its centre and places the byte in a one-entry receive buffer with its own empty flag. Each direction raises a one-cycle completion pulse per frame.

Top module: `uart_duplex`

## Requirements
- R1: One transfer clock lasts 8 `baud_tick` pulses when `div_sel` is 0 and 16 pulses when it is 1. All transmit and receive timing below scales with that value.
- R2: A `tx_wr` in a cycle where `tx_full` is 0 is accepted, and `tx_full` reads 1 from the next cycle. A `tx_wr` while `tx_full` is 1 is ignored and does not change the frame in flight.
- R3: `txd` goes low after exactly 2.5 transfer clocks of `baud_tick` pulses, counting the pulses in the cycles after the accepted write. `txd` stays high until then.
- R4: The transmit frame is one low start bit, then `tx_data` bit 0 through bit 7, then one high stop bit, each lasting one transfer clock. The line idles high.
- R5: At the end of the stop bit, `tx_done_irq` is high for exactly one cycle, and `tx_full` reads 0 in that same cycle.
- R6: A low level on `rxd` that does not last half a transfer clock is ignored. No byte is stored and no `rx_done_irq` is raised.
- R7: After a confirmed start bit, each data bit is sampled at its centre. At the centre of the stop bit, `rx_data` takes the byte (first received bit in bit 0), `rx_empty` reads 0, and `rx_done_irq` is high for exactly one cycle. The stop bit's level is not checked.
- R8: `rx_rd` while `rx_empty` is 0 sets `rx_empty` to 1 and clears `rx_overrun` from the next cycle. `rx_rd` while `rx_empty` is 1 changes neither flag nor `rx_data`.
- R9: A frame that completes while `rx_empty` is 0, with no read in that cycle, overwrites `rx_data` and sets `rx_overrun`. The flag stays set until the next read.
- R10: While `rst_n` is low: `txd`=1, `tx_full`=0, `tx_done_irq`=0, `rx_empty`=1, `rx_overrun`=0, `rx_done_irq`=0, `rx_data`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle enable from the external rate timer |
| div_sel | input | 1 | Transfer clock divide select: 0 = /8, 1 = /16 |
| tx_wr | input | 1 | Transmit buffer write strobe |
| tx_data | input | 8 | Byte to transmit |
| tx_full | output | 1 | Transmit buffer holds unsent data |
| txd | output | 1 | Serial transmit line |
| tx_done_irq | output | 1 | One-cycle pulse per transmitted frame |
| rxd | input | 1 | Serial receive line (asynchronous) |
| rx_rd | input | 1 | Receive buffer read strobe |
| rx_data | output | 8 | Receive buffer contents |
| rx_empty | output | 1 | Receive buffer holds no unread byte |
| rx_overrun | output | 1 | Sticky flag: an unread byte was overwritten |
| rx_done_irq | output | 1 | One-cycle pulse per received frame |

## Verification
On the transmit side, a corrupted phase counter or divider count shows up on `txd`. A bit edge arrives early or late relative to the counted `baud_tick` pulses, and this is visible within one half transfer clock of the fault. A corrupted shift register shows up as a wrong data bit within one transfer clock. On the receive side, a wrong state or centre count shows up only at frame end, as a wrong `rx_data` byte, a missing or doubled `rx_done_irq`, or a frame accepted from a glitch. That is up to 9.5 transfer clocks after the start edge. A wrong buffer flag is exposed by the next read or the next completed frame.

// File: rtl/uart_duplex_pkg.sv
package uart_duplex_pkg;
  localparam int DATA_W    = 8;
  // transmit phases, counted in half transfer clocks from the buffer write
  localparam int TX_START  = 5;
  localparam int TX_DATA   = TX_START + 2;
  localparam int TX_STOP   = TX_DATA + 2 * DATA_W;
  localparam int TX_END    = TX_STOP + 2;
  // receive half counts from the confirmed start (0.5 bit into the start bit)
  localparam int RX_LAST_SAMPLE = 2 * DATA_W;
  localparam int RX_END         = RX_LAST_SAMPLE + 2;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_CONF  = 2'd1,
    RX_SHIFT = 2'd2
  } rx_state_e;
endpackage

// File: rtl/uart_halfdiv.sv
module uart_halfdiv #(
  parameter int DIV_LO = 8,
  parameter int DIV_HI = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic div_sel,
  input  logic restart,
  output logic half_tick
);
  localparam int CW = $clog2(DIV_HI / 2 + 1);
  localparam logic [CW-1:0] LIM_LO = CW'(DIV_LO / 2 - 1);
  localparam logic [CW-1:0] LIM_HI = CW'(DIV_HI / 2 - 1);

  logic [CW-1:0] cnt_q, cnt_d, lim;

  assign lim       = div_sel ? LIM_HI : LIM_LO;
  assign half_tick = !restart && tick && (cnt_q == lim);

  always_comb begin
    cnt_d = cnt_q;
    if (restart)   cnt_d = '0;
    else if (tick) cnt_d = (cnt_q == lim) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/uart_tx_path.sv
module uart_tx_path
  import uart_duplex_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              half_tick,
  input  logic              wr,
  input  logic [DATA_W-1:0] din,
  output logic              restart,
  output logic              busy,
  output logic              txd,
  output logic              done
);
  localparam int PH_W = $clog2(TX_END + 1);
  localparam logic [PH_W-1:0] P_START = PH_W'(TX_START);
  localparam logic [PH_W-1:0] P_DATA  = PH_W'(TX_DATA);
  localparam logic [PH_W-1:0] P_STOP  = PH_W'(TX_STOP);
  localparam logic [PH_W-1:0] P_LAST  = PH_W'(TX_END - 1);

  logic              busy_q, busy_d;
  logic [PH_W-1:0]   ph_q, ph_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic              txd_q, txd_d;
  logic              done_q, done_d;

  assign restart = wr && !busy_q;

  always_comb begin
    busy_d = busy_q;
    ph_d   = ph_q;
    sh_d   = sh_q;
    done_d = 1'b0;
    if (!busy_q) begin
      if (wr) begin
        busy_d = 1'b1;
        ph_d   = '0;
        sh_d   = din;
      end
    end else if (half_tick) begin
      if (ph_q == P_LAST) begin
        busy_d = 1'b0;
        ph_d   = '0;
        done_d = 1'b1;
      end else begin
        ph_d = ph_q + 1'b1;
        // second half of a data bit ends: move to the next bit
        if (ph_q >= P_DATA && ph_q < P_STOP && ph_q[0] != P_DATA[0])
          sh_d = {1'b0, sh_q[DATA_W-1:1]};
      end
    end
    txd_d = 1'b1;
    if (busy_d) begin
      if (ph_d >= P_START && ph_d < P_DATA)     txd_d = 1'b0;
      else if (ph_d >= P_DATA && ph_d < P_STOP) txd_d = sh_d[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ph_q   <= '0;
      sh_q   <= '0;
      txd_q  <= 1'b1;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      ph_q   <= ph_d;
      sh_q   <= sh_d;
      txd_q  <= txd_d;
      done_q <= done_d;
    end
  end

  assign busy = busy_q;
  assign txd  = txd_q;
  assign done = done_q;
endmodule

// File: rtl/uart_rx_path.sv
module uart_rx_path
  import uart_duplex_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              half_tick,
  input  logic              rxd_s,
  output logic              restart,
  output logic              done,
  output logic [DATA_W-1:0] data
);
  localparam int HW = $clog2(RX_END + 1);
  localparam logic [HW-1:0] H_LAST_SAMPLE = HW'(RX_LAST_SAMPLE);
  localparam logic [HW-1:0] H_END         = HW'(RX_END);

  rx_state_e         st_q, st_d;
  logic [HW-1:0]     hc_q, hc_d, hc_n;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic              done_q, done_d;

  assign restart = (st_q == RX_IDLE) && !rxd_s;
  assign hc_n    = hc_q + 1'b1;

  always_comb begin
    st_d   = st_q;
    hc_d   = hc_q;
    sh_d   = sh_q;
    done_d = 1'b0;
    unique case (st_q)
      RX_IDLE: if (!rxd_s) st_d = RX_CONF;
      RX_CONF: begin
        if (rxd_s) st_d = RX_IDLE;
        else if (half_tick) begin
          st_d = RX_SHIFT;
          hc_d = '0;
        end
      end
      RX_SHIFT: begin
        if (half_tick) begin
          hc_d = hc_n;
          if (!hc_n[0] && hc_n <= H_LAST_SAMPLE)
            sh_d = {rxd_s, sh_q[DATA_W-1:1]};
          if (hc_n == H_END) begin
            st_d   = RX_IDLE;
            done_d = 1'b1;
          end
        end
      end
      default: st_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RX_IDLE;
      hc_q   <= '0;
      sh_q   <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      hc_q   <= hc_d;
      sh_q   <= sh_d;
      done_q <= done_d;
    end
  end

  assign done = done_q;
  assign data = sh_q;
endmodule

// File: rtl/uart_duplex.sv
module uart_duplex
  import uart_duplex_pkg::*;
#(
  parameter int DIV_LO = 8,
  parameter int DIV_HI = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              div_sel,
  input  logic              tx_wr,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_full,
  output logic              txd,
  output logic              tx_done_irq,
  input  logic              rxd,
  input  logic              rx_rd,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_empty,
  output logic              rx_overrun,
  output logic              rx_done_irq
);
  logic              tx_restart, tx_half;
  logic              rx_restart, rx_half;
  logic              fr_done;
  logic [DATA_W-1:0] fr_data;
  logic [1:0]        sync_q;

  logic [DATA_W-1:0] buf_q, buf_d;
  logic              empty_q, empty_d;
  logic              ovr_q, ovr_d;
  logic              irq_q, irq_d;
  logic              rd_ok;

  uart_halfdiv #(.DIV_LO(DIV_LO), .DIV_HI(DIV_HI)) u_tx_div (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .div_sel(div_sel),
    .restart(tx_restart), .half_tick(tx_half)
  );

  uart_tx_path u_tx (
    .clk(clk), .rst_n(rst_n), .half_tick(tx_half), .wr(tx_wr), .din(tx_data),
    .restart(tx_restart), .busy(tx_full), .txd(txd), .done(tx_done_irq)
  );

  uart_halfdiv #(.DIV_LO(DIV_LO), .DIV_HI(DIV_HI)) u_rx_div (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .div_sel(div_sel),
    .restart(rx_restart), .half_tick(rx_half)
  );

  uart_rx_path u_rx (
    .clk(clk), .rst_n(rst_n), .half_tick(rx_half), .rxd_s(sync_q[1]),
    .restart(rx_restart), .done(fr_done), .data(fr_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], rxd};
  end

  assign rd_ok = rx_rd && !empty_q;

  always_comb begin
    buf_d   = buf_q;
    empty_d = empty_q;
    ovr_d   = ovr_q;
    irq_d   = fr_done;
    if (rd_ok) begin
      empty_d = 1'b1;
      ovr_d   = 1'b0;
    end
    if (fr_done) begin
      buf_d   = fr_data;
      empty_d = 1'b0;
      if (!empty_q && !rx_rd) ovr_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q   <= '0;
      empty_q <= 1'b1;
      ovr_q   <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      buf_q   <= buf_d;
      empty_q <= empty_d;
      ovr_q   <= ovr_d;
      irq_q   <= irq_d;
    end
  end

  assign rx_data     = buf_q;
  assign rx_empty    = empty_q;
  assign rx_overrun  = ovr_q;
  assign rx_done_irq = irq_q;
endmodule

// File: rtl/uart_duplex_chk.sv
module uart_duplex_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_wr,
  input logic tx_full,
  input logic txd,
  input logic tx_done_irq,
  input logic rx_rd,
  input logic rx_empty,
  input logic rx_overrun,
  input logic rx_done_irq
);
  // R2
  tx_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_full) |-> $past(tx_wr));

  // R4
  tx_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !txd |-> tx_full);

  // R5
  tx_irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done_irq |=> !tx_done_irq);

  // R5
  tx_irq_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done_irq |-> !tx_full);

  // R7
  rx_irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done_irq |=> !rx_done_irq);

  // R7
  rx_irq_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done_irq |-> !rx_empty);

  // R8
  rx_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rd && !rx_empty) |=> (rx_empty || rx_done_irq));

  // R9
  rx_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done_irq && !$past(rx_empty) && !$past(rx_rd)) |-> rx_overrun);
endmodule

bind uart_duplex uart_duplex_chk u_uart_duplex_chk (
  .clk(clk), .rst_n(rst_n), .tx_wr(tx_wr), .tx_full(tx_full), .txd(txd),
  .tx_done_irq(tx_done_irq), .rx_rd(rx_rd), .rx_empty(rx_empty),
  .rx_overrun(rx_overrun), .rx_done_irq(rx_done_irq)
);

// File: tb/uart_duplex_bench.sv
module uart_duplex_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b0;
  logic       div_sel = 1'b0;
  logic       tx_wr = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic       rxd = 1'b1;
  logic       rx_rd = 1'b0;
  logic       tx_full, txd, tx_done_irq;
  logic [7:0] rx_data;
  logic       rx_empty, rx_overrun, rx_done_irq;

  int vectors = 0;
  int fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  uart_duplex u_uart_duplex (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .div_sel(div_sel),
    .tx_wr(tx_wr), .tx_data(tx_data), .tx_full(tx_full), .txd(txd),
    .tx_done_irq(tx_done_irq), .rxd(rxd), .rx_rd(rx_rd), .rx_data(rx_data),
    .rx_empty(rx_empty), .rx_overrun(rx_overrun), .rx_done_irq(rx_done_irq)
  );

  task automatic check(string req, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // expected line level k ticks after an accepted write
  function automatic logic exp_txd(int k, int h, logic [7:0] d, logic full);
    int ph;
    if (!full) return 1'b1;
    ph = k / h;
    if (ph < 5)  return 1'b1;
    if (ph < 7)  return 1'b0;
    if (ph < 23) return d[(ph - 7) / 2];
    return 1'b1;
  endfunction

  function automatic int ticks_per_bit(logic sel);
    return sel ? 16 : 8;
  endfunction

  // transmit reference model (R1-R5)
  logic       m_full = 1'b0, m_irq = 1'b0;
  logic [7:0] m_data = 8'h00;
  int         m_k = 0, m_h = 4;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_full = 1'b0; m_irq = 1'b0; m_k = 0;
    end else begin
      m_irq = 1'b0;
      if (!m_full) begin
        if (tx_wr) begin
          m_full = 1'b1; m_k = 0; m_data = tx_data;
          m_h = ticks_per_bit(div_sel) / 2;
        end
      end else if (baud_tick) begin
        m_k++;
        if (m_k == 25 * m_h) begin
          m_full = 1'b0; m_irq = 1'b1;
        end
      end
    end
  end

  int  rx_irq_cnt = 0;
  bit  rx_irq_prev = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      // R10
      check("R10", "txd", txd, 1);
      check("R10", "tx_full", tx_full, 0);
      check("R10", "tx_done_irq", tx_done_irq, 0);
      check("R10", "rx_empty", rx_empty, 1);
      check("R10", "rx_overrun", rx_overrun, 0);
      check("R10", "rx_done_irq", rx_done_irq, 0);
      check("R10", "rx_data", rx_data, 0);
    end else begin
      // R3 R4 with timing per R1
      check("R4", "txd", txd, exp_txd(m_k, m_h, m_data, m_full));
      // R2
      check("R2", "tx_full", tx_full, m_full);
      // R5
      check("R5", "tx_done_irq", tx_done_irq, m_irq);
      if (rx_done_irq) begin
        rx_irq_cnt++;
        // R7 single-cycle pulse
        if (rx_irq_prev) check("R7", "rx_done_irq width", 2, 1);
      end
      rx_irq_prev = rx_done_irq;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    forever begin
      @(negedge clk);
      baud_tick = ($urandom % 100) < 60;
    end
  end

  task automatic wait_ticks(int n);
    int c = 0;
    while (c < n) begin
      @(posedge clk);
      if (baud_tick) c++;
    end
    @(negedge clk);
  endtask

  task automatic tx_run(int nframes);
    for (int i = 0; i < nframes; i++) begin
      while (tx_full) @(negedge clk);
      if ($urandom % 3 == 0) repeat ($urandom % 20) @(negedge clk);
      tx_wr = 1'b1;
      tx_data = (i == 0) ? 8'h00 : (i == 1) ? 8'hFF : (i == 2) ? 8'h5A : 8'($urandom);
      @(negedge clk);
      tx_wr = 1'b0;
      while (tx_full) begin
        // R2 writes while busy must be ignored
        tx_wr = ($urandom % 8) == 0;
        tx_data = 8'($urandom);
        @(negedge clk);
      end
      tx_wr = 1'b0;
    end
  endtask

  task automatic rx_send(logic [7:0] b);
    int n = ticks_per_bit(div_sel);
    rxd = 1'b0; wait_ticks(n);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i]; wait_ticks(n);
    end
    rxd = 1'b1; wait_ticks(n);
  endtask

  task automatic rx_read();
    rx_rd = 1'b1;
    @(negedge clk);
    rx_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic rx_run();
    int         base;
    logic [7:0] b, b2;
    for (int i = 0; i < 6; i++) begin
      b = (i == 0) ? 8'h00 : (i == 1) ? 8'hFF : (i == 2) ? 8'hA5 : 8'($urandom);
      base = rx_irq_cnt;
      rx_send(b);
      // R7
      check("R7", "rx_data", rx_data, b);
      check("R7", "rx_empty", rx_empty, 0);
      check("R7", "rx_done_irq count", rx_irq_cnt - base, 1);
      rx_read();
      // R8
      check("R8", "rx_empty after read", rx_empty, 1);
      check("R8", "rx_overrun after read", rx_overrun, 0);
      b2 = rx_data;
      rx_read();
      // R8 read while empty
      check("R8", "rx_empty on empty read", rx_empty, 1);
      check("R8", "rx_data on empty read", rx_data, b2);
    end
    // R6 short low pulse
    base = rx_irq_cnt;
    rxd = 1'b0; wait_ticks(1); rxd = 1'b1;
    wait_ticks(3 * ticks_per_bit(div_sel));
    check("R6", "rx_empty after glitch", rx_empty, 1);
    check("R6", "irq after glitch", rx_irq_cnt - base, 0);
    // R9 overrun
    b = 8'($urandom); b2 = ~b;
    rx_send(b);
    check("R9", "rx_overrun first", rx_overrun, 0);
    rx_send(b2);
    check("R9", "rx_data overwritten", rx_data, b2);
    check("R9", "rx_overrun set", rx_overrun, 1);
    wait_ticks(ticks_per_bit(div_sel));
    check("R9", "rx_overrun sticky", rx_overrun, 1);
    rx_read();
    check("R8", "rx_overrun cleared", rx_overrun, 0);
    check("R8", "rx_empty after overrun read", rx_empty, 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 both divide ratios
    for (int s = 0; s < 2; s++) begin
      div_sel = s[0];
      @(negedge clk);
      fork
        tx_run(10);
        rx_run();
      join
    end
    repeat (10) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule